// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer

This block is a down-counting timer with no waveform output. It is meant to produce a periodic or one-shot interrupt. Software places a period value in a count buffer. A manual-update control bit copies that buffer into the counter. The counter then steps down by one on each tick enable from an external prescaler, but only while the start bit is set.

When the count has reached zero, the next tick raises a one-cycle interrupt pulse and ends the period. With auto-reload enabled, the counter takes the buffer value again and keeps running. Otherwise the counter stays at zero and hardware clears the start bit. A write to the buffer never disturbs the running count. The new value takes effect at the next reload or the next manual update. The present count can always be read from a separate read-only output.

The usual programming sequence has two steps. First, write the buffer with manual update set. Then, in a later write, clear manual update and set start, with auto-reload as required.

Top module: `auto_reload_timer`

## Requirements
- R1: After a synchronous reset, the count is 0, the interrupt is low and the start readback is 0.
- R2: A buffer write while manual update is 0 leaves the count output unchanged.
- R3: While the registered manual-update bit is 1, the counter takes the buffer value every cycle. It does not decrement and raises no interrupt, even with start set and ticks present.
- R4: With start set and manual update 0, each cycle with tick enable high lowers a non-zero count by exactly one. A cycle without tick enable leaves the count unchanged.
- R5: With auto-reload set, a tick while the count is 0 loads the buffer value. For a buffer of 3 the observed sequence is 3,2,1,0,3,2,...
- R6: The interrupt output is high for exactly the one cycle after each tick taken at count 0, and low in every other cycle.
- R7: With auto-reload clear, a tick at count 0 pulses the interrupt, leaves the count at 0 and clears the start readback. Further ticks produce no interrupt.
- R8: With a buffer value of 0 and auto-reload set, every tick pulses the interrupt and the count stays 0.
- R9: A buffer value written during a running period is used at the next reload after the count reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable from the prescaler, one cycle per step |
| buf_wr | input | 1 | Write strobe for the count buffer |
| buf_data | input | 16 | Value written into the count buffer |
| ctl_wr | input | 1 | Write strobe for the control bits |
| ctl_load | input | 1 | Manual-update bit: copy the buffer into the counter while held |
| ctl_run | input | 1 | Start bit |
| ctl_auto | input | 1 | Auto-reload enable |
| count_o | output | 16 | Current count, read-only |
| run_o | output | 1 | Readback of the start bit, including its hardware clear |
| irq_o | output | 1 | One-cycle interrupt pulse at each expiry |

## Verification
The hardest case to reach from the ports is a change of the buffer during a running period. The stimulus must show both that the count stays put (R2) and that the new value appears only at the following reload (R9). The bench stops the ticks so that it can observe the count right after the write. It then counts the remaining period down tick by tick and checks the reloaded value. The one-shot stop (R7) and the zero-period case (R8) each need a fresh manual update with a different control setting. The bench reaches them through directed sequences that follow the vector table.

// File: rtl/art_pkg.sv
package art_pkg;
  typedef struct packed {
    logic load;
    logic run;
    logic auto_rl;
  } art_ctl_t;
endpackage

// File: rtl/art_regs.sv
module art_regs
  import art_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_data,
  input  logic         ctl_wr,
  input  logic         ctl_load,
  input  logic         ctl_run,
  input  logic         ctl_auto,
  input  logic         hw_stop,
  output logic [W-1:0] buf_q,
  output art_ctl_t     ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
    end else if (buf_wr) begin
      buf_q <= buf_data;
    end
  end

  // Software write takes precedence over the hardware clear of start.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q.load    <= ctl_load;
      ctl_q.run     <= ctl_run;
      ctl_q.auto_rl <= ctl_auto;
    end else if (hw_stop) begin
      ctl_q.run <= 1'b0;
    end
  end
endmodule

// File: rtl/art_counter.sv
module art_counter
  import art_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] buf_q,
  input  art_ctl_t     ctl_q,
  output logic [W-1:0] cnt_q,
  output logic         irq_q,
  output logic         hw_stop
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic step;
  logic at_zero;
  logic expire;

  assign step    = ctl_q.run && tick_en && !ctl_q.load;
  assign at_zero = (cnt_q == ZERO);
  assign expire  = step && at_zero;
  assign hw_stop = expire && !ctl_q.auto_rl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
    end else if (ctl_q.load) begin
      cnt_q <= buf_q;
    end else if (expire) begin
      cnt_q <= ctl_q.auto_rl ? buf_q : ZERO;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire;
    end
  end
endmodule

// File: rtl/auto_reload_timer.sv
module auto_reload_timer
  import art_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_data,
  input  logic         ctl_wr,
  input  logic         ctl_load,
  input  logic         ctl_run,
  input  logic         ctl_auto,
  output logic [W-1:0] count_o,
  output logic         run_o,
  output logic         irq_o
);
  logic [W-1:0] buf_q;
  art_ctl_t     ctl_q;
  logic         hw_stop;
  logic [W-1:0] cnt_q;
  logic         irq_q;

  art_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .buf_wr   (buf_wr),
    .buf_data (buf_data),
    .ctl_wr   (ctl_wr),
    .ctl_load (ctl_load),
    .ctl_run  (ctl_run),
    .ctl_auto (ctl_auto),
    .hw_stop  (hw_stop),
    .buf_q    (buf_q),
    .ctl_q    (ctl_q)
  );

  art_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .buf_q   (buf_q),
    .ctl_q   (ctl_q),
    .cnt_q   (cnt_q),
    .irq_q   (irq_q),
    .hw_stop (hw_stop)
  );

  assign count_o = cnt_q;
  assign run_o   = ctl_q.run;
  assign irq_o   = irq_q;
endmodule

// File: rtl/art_chk.sv
module art_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic         ctl_wr,
  input logic [W-1:0] count_o,
  input logic         run_o,
  input logic         irq_o,
  input logic [W-1:0] buf_q,
  input logic         load_q,
  input logic         auto_q
);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(count_o) == '0 && $past(tick_en) && $past(run_o) && !$past(load_q)));

  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(auto_q)) |-> (count_o == $past(buf_q)));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !$past(auto_q) && !$past(ctl_wr)) |-> (count_o == '0 && !run_o));

  // R3
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(load_q) |-> (count_o == $past(buf_q) && !irq_o));

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick_en) && !$past(load_q)) |-> $stable(count_o));

  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tick_en) && $past(run_o) && !$past(load_q) && $past(count_o) != '0)
      |-> (count_o == $past(count_o) - 1'b1));
endmodule

bind auto_reload_timer art_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .ctl_wr  (ctl_wr),
  .count_o (count_o),
  .run_o   (run_o),
  .irq_o   (irq_o),
  .buf_q   (buf_q),
  .load_q  (ctl_q.load),
  .auto_q  (ctl_q.auto_rl)
);

// File: tb/tb_auto_reload_timer.sv
module tb_auto_reload_timer;
  localparam int W  = 16;
  localparam int NV = 12;
  // each vector: {tick, expected count, expected irq}
  localparam logic [W+1:0] VEC [NV] = '{
    {1'b1, 16'd2, 1'b0},
    {1'b1, 16'd1, 1'b0},
    {1'b0, 16'd1, 1'b0},
    {1'b1, 16'd0, 1'b0},
    {1'b1, 16'd3, 1'b1},
    {1'b1, 16'd2, 1'b0},
    {1'b0, 16'd2, 1'b0},
    {1'b1, 16'd1, 1'b0},
    {1'b1, 16'd0, 1'b0},
    {1'b0, 16'd0, 1'b0},
    {1'b1, 16'd3, 1'b1},
    {1'b1, 16'd2, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         buf_wr = 1'b0;
  logic [W-1:0] buf_data = '0;
  logic         ctl_wr = 1'b0;
  logic         ctl_load = 1'b0;
  logic         ctl_run = 1'b0;
  logic         ctl_auto = 1'b0;
  logic [W-1:0] count_o;
  logic         run_o;
  logic         irq_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  auto_reload_timer #(.W(W)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .buf_wr(buf_wr), .buf_data(buf_data),
    .ctl_wr(ctl_wr), .ctl_load(ctl_load), .ctl_run(ctl_run), .ctl_auto(ctl_auto),
    .count_o(count_o), .run_o(run_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: apply inputs, clock, then sample 1 ns after the edge
  task automatic cyc();
    @(posedge clk);
    #1;
    buf_wr = 1'b0;
    ctl_wr = 1'b0;
  endtask

  task automatic prog(input logic [W-1:0] val, input logic aut);
    buf_wr = 1'b1; buf_data = val;
    ctl_wr = 1'b1; ctl_load = 1'b1; ctl_run = 1'b0; ctl_auto = 1'b0;
    tick_en = 1'b0;
    cyc();
    cyc();
    ctl_wr = 1'b1; ctl_load = 1'b0; ctl_run = 1'b1; ctl_auto = aut;
    cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 run", run_o, 0);

    // R5 R6 R4 table walk with buffer 3, auto-reload
    prog(16'd3, 1'b1);
    chk("R5 start value", count_o, 3);
    for (int i = 0; i < NV; i++) begin
      tick_en = VEC[i][W+1];
      cyc();
      chk("R5 R4 count", count_o, int'(VEC[i][W:1]));
      chk("R6 irq", irq_o, int'(VEC[i][0]));
    end
    // count is now 2
    // R2 buffer write does not touch the count
    tick_en = 1'b0;
    buf_wr = 1'b1; buf_data = 16'd7;
    cyc();
    cyc();
    chk("R2 count unchanged", count_o, 2);
    // R9 new buffer used at next reload
    tick_en = 1'b1;
    cyc(); chk("R9 count", count_o, 1);
    cyc(); chk("R9 count", count_o, 0);
    cyc(); chk("R9 reload", count_o, 7);
    chk("R9 irq", irq_o, 1);
    cyc(); chk("R9 after", count_o, 6);
    chk("R6 low", irq_o, 0);

    // R3 manual update held: counter follows buffer, no decrement
    ctl_wr = 1'b1; ctl_load = 1'b1; ctl_run = 1'b1; ctl_auto = 1'b1;
    buf_wr = 1'b1; buf_data = 16'd9;
    cyc();
    cyc(); chk("R3 loaded", count_o, 9);
    cyc(); chk("R3 held", count_o, 9);
    chk("R3 irq", irq_o, 0);
    buf_wr = 1'b1; buf_data = 16'd4;
    cyc();
    cyc(); chk("R3 follows buffer", count_o, 4);

    // R7 one-shot
    prog(16'd2, 1'b0);
    tick_en = 1'b1;
    cyc(); chk("R7 count", count_o, 1);
    cyc(); chk("R7 count", count_o, 0);
    cyc(); chk("R7 stop count", count_o, 0);
    chk("R7 irq", irq_o, 1);
    chk("R7 run cleared", run_o, 0);
    cyc(); chk("R7 no irq", irq_o, 0);
    cyc(); chk("R7 hold", count_o, 0);
    chk("R7 no irq", irq_o, 0);

    // R8 zero period with auto-reload
    prog(16'd0, 1'b1);
    tick_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R8 irq", irq_o, 1);
      chk("R8 count", count_o, 0);
    end
    tick_en = 1'b0;
    cyc(); chk("R8 no tick", irq_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule